// File: doc/BRIEF.md
# Syndrome Bit-Flip Post-Processor

This block cleans up the few residual errors that a complexity-reduced LDPC decoder may leave behind. It receives the decoder's final hard decisions and the matching syndrome, which marks the parity checks that are still violated. It then repairs the word by flipping single bits, one at a time.

In each round the block scores every variable node. The score is the number of violated checks the node belongs to. The block inverts the bit with the highest score and toggles the syndrome bits of that node's column, so the syndrome is never recomputed from the word. Rounds stop when the syndrome becomes zero, when no node touches a violated check, or when the round budget is used up. If the incoming syndrome already has more violated checks than twice the round budget, the block skips correction altogether and reports failure. The parity-check matrix is a compile-time parameter given as packed columns.

Top module: `bf_postproc`

## Requirements
- R1: After reset the outputs `busy`, `done`, `success` and `failure` are 0, and `word_out` is all zeros.
- R2: If the number of set bits in `synd_in` is greater than 2·ROUND_LIMIT when `start` is sampled, no bit is flipped. In that case `word_out` equals `hard_in`, `failure` is 1 and `success` is 0.
- R3: Each round inverts exactly one bit. That bit belongs to the variable whose column (bits `[i*N_CHK +: N_CHK]` of `H_COLS`, bit j set when check j covers variable i) shares the most set bits with the current syndrome.
- R4: When several variables tie on the highest score, the variable with the lowest index is flipped.
- R5: After a flip of variable i, the working syndrome equals the previous one XOR column i. A run ends in success exactly when this syndrome reaches zero.
- R6: A run whose syndrome is zero at start, or becomes zero, ends with `success`=1 and `failure`=0. `word_out` then holds the corrected word, and a zero input syndrome leaves it equal to `hard_in`.
- R7: If ROUND_LIMIT flips have been made and the syndrome is still nonzero, the run ends with `failure`=1 and `success`=0.
- R8: If the syndrome is nonzero but every variable scores zero, the run ends at once with `failure`=1 and no further flip.
- R9: Let F be the number of flips. In a run that is not bypassed, `done` is seen after the (F+2)-th rising edge counted from the edge that samples `start`. A bypassed run shows `done` after the first edge. `done` is high for one cycle.
- R10: `busy` is high while rounds are in progress, and `start` is ignored while `busy` is high. When `done` is high, exactly one of `success`/`failure` is set, and both flags hold their value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the word and syndrome presented |
| hard_in | input | N_VAR | Hard-decision word from the decoder |
| synd_in | input | N_CHK | Violated-check vector for `hard_in` |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| word_out | output | N_VAR | Corrected (or passed-through) word |
| success | output | 1 | Run ended with all checks satisfied |
| failure | output | 1 | Run ended by bypass, round limit or zero score |

## Verification
The working syndrome and the word are updated together once per round. A wrong score, a wrong tie choice or a wrong column toggle therefore changes which bits end up in `word_out`, and it shows at the `done` of the same run. A stray or missing flip also moves `done` by one cycle per extra or missing round, so the bench checks the latency of every run against its own count of flips. A bypass decision taken on the wrong side of the threshold shows as flipped bits, or as an early `failure`, on the very first pulse.

// File: rtl/bf_pkg.sv
package bf_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bf_state_e;

endpackage

// File: rtl/bf_unsat_count.sv
// Scores every variable node: violated checks in its column.
module bf_unsat_count #(
   parameter int N_VAR = 10,
   parameter int N_CHK = 5,
   parameter logic [N_VAR*N_CHK-1:0] H_COLS = '0,
   localparam int CNT_W = $clog2(N_CHK + 1)
) (
   input  logic [N_CHK-1:0]            syndrome,
   output logic [N_VAR-1:0][CNT_W-1:0] score
);

   for (genvar v = 0; v < N_VAR; v++) begin : g_var
      localparam logic [N_CHK-1:0] COL = H_COLS[v*N_CHK +: N_CHK];
      logic [N_CHK-1:0] hit;
      assign hit = syndrome & COL;
      always_comb begin
         score[v] = '0;
         for (int c = 0; c < N_CHK; c++) begin
            score[v] = score[v] + CNT_W'(hit[c]);
         end
      end
   end

endmodule

// File: rtl/bf_select_worst.sv
// Picks the highest score; a later index wins only on a strictly greater score.
module bf_select_worst #(
   parameter int N_VAR = 10,
   parameter int N_CHK = 5,
   localparam int CNT_W = $clog2(N_CHK + 1),
   localparam int IDX_W = (N_VAR > 1) ? $clog2(N_VAR) : 1
) (
   input  logic [N_VAR-1:0][CNT_W-1:0] score,
   output logic [CNT_W-1:0]            best_cnt,
   output logic [IDX_W-1:0]            best_idx,
   output logic [N_VAR-1:0]            flip_oh
);

   always_comb begin
      best_cnt = score[0];
      best_idx = '0;
      for (int v = 1; v < N_VAR; v++) begin
         if (score[v] > best_cnt) begin
            best_cnt = score[v];
            best_idx = IDX_W'(v);
         end
      end
   end

   always_comb begin
      flip_oh = '0;
      if (best_cnt != '0) begin
         flip_oh[best_idx] = 1'b1;
      end
   end

endmodule

// File: rtl/bf_synd_weight.sv
// Counts the violated checks presented with start.
module bf_synd_weight #(
   parameter int N_CHK = 5,
   localparam int WGT_W = $clog2(N_CHK + 1)
) (
   input  logic [N_CHK-1:0] syndrome,
   output logic [WGT_W-1:0] weight
);

   always_comb begin
      weight = '0;
      for (int c = 0; c < N_CHK; c++) begin
         weight = weight + WGT_W'(syndrome[c]);
      end
   end

endmodule

// File: rtl/bf_postproc.sv
module bf_postproc
   import bf_pkg::*;
#(
   parameter int N_VAR       = 10,
   parameter int N_CHK       = 5,
   parameter int ROUND_LIMIT = 30,
   parameter logic [N_VAR*N_CHK-1:0] H_COLS =
      50'b11000_10100_01100_10010_01010_00110_10001_01001_00101_00011
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [N_VAR-1:0] hard_in,
   input  logic [N_CHK-1:0] synd_in,
   output logic             busy,
   output logic             done,
   output logic [N_VAR-1:0] word_out,
   output logic             success,
   output logic             failure
);

   localparam int CNT_W   = $clog2(N_CHK + 1);
   localparam int IDX_W   = (N_VAR > 1) ? $clog2(N_VAR) : 1;
   localparam int RND_W   = $clog2(ROUND_LIMIT + 1);
   localparam int BYP_LIM = 2 * ROUND_LIMIT;

   // elaboration-time parameter checks
   if (N_VAR < 2) begin : g_chk_var
      $error("bf_postproc: N_VAR must be at least 2");
   end
   if (N_CHK < 1) begin : g_chk_chk
      $error("bf_postproc: N_CHK must be at least 1");
   end
   if (ROUND_LIMIT < 1) begin : g_chk_lim
      $error("bf_postproc: ROUND_LIMIT must be at least 1");
   end
   for (genvar v = 0; v < N_VAR; v++) begin : g_chk_col
      if (H_COLS[v*N_CHK +: N_CHK] == '0) begin : g_empty
         $error("bf_postproc: every column of H_COLS needs a set bit");
      end
   end

   bf_state_e              state_q;
   logic [N_VAR-1:0]       word_q;
   logic [N_CHK-1:0]       synd_q;
   logic [RND_W-1:0]       round_q;
   logic                   done_q, succ_q, fail_q;

   logic [N_VAR-1:0][CNT_W-1:0] score;
   logic [CNT_W-1:0]       best_cnt;
   logic [IDX_W-1:0]       best_idx;
   logic [N_VAR-1:0]       flip_oh;
   logic [N_CHK-1:0]       flip_col;
   logic [CNT_W-1:0]       in_wgt;
   logic                   bypass;

   bf_unsat_count #(.N_VAR(N_VAR), .N_CHK(N_CHK), .H_COLS(H_COLS)) u_count (
      .syndrome (synd_q),
      .score    (score)
   );

   bf_select_worst #(.N_VAR(N_VAR), .N_CHK(N_CHK)) u_select (
      .score    (score),
      .best_cnt (best_cnt),
      .best_idx (best_idx),
      .flip_oh  (flip_oh)
   );

   bf_synd_weight #(.N_CHK(N_CHK)) u_weight (
      .syndrome (synd_in),
      .weight   (in_wgt)
   );

   assign bypass = 32'(in_wgt) > 32'(BYP_LIM);

   always_comb begin
      flip_col = '0;
      for (int v = 0; v < N_VAR; v++) begin
         if (flip_oh[v]) begin
            flip_col = flip_col ^ H_COLS[v*N_CHK +: N_CHK];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         synd_q  <= '0;
         round_q <= '0;
         done_q  <= 1'b0;
         succ_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  word_q  <= hard_in;
                  synd_q  <= synd_in;
                  round_q <= '0;
                  succ_q  <= 1'b0;
                  if (bypass) begin
                     done_q <= 1'b1;
                     fail_q <= 1'b1;
                  end else begin
                     fail_q  <= 1'b0;
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (synd_q == '0) begin
                  done_q  <= 1'b1;
                  succ_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (best_cnt == '0 || round_q == RND_W'(ROUND_LIMIT)) begin
                  done_q  <= 1'b1;
                  fail_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  word_q  <= word_q ^ flip_oh;
                  synd_q  <= synd_q ^ flip_col;
                  round_q <= round_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q == ST_RUN);
   assign done     = done_q;
   assign word_out = word_q;
   assign success  = succ_q;
   assign failure  = fail_q;

   // R2: an oversized syndrome passes the word through and fails
   assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start && bypass) |=>
         (done_q && fail_q && !succ_q && word_q == $past(hard_in)));

   // R3: a round changes at most one bit of the word
   assert_single_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> ($countones(word_q ^ $past(word_q)) <= 1));

   // R5: word and syndrome move in the same rounds
   assert_synd_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> ((word_q != $past(word_q)) == (synd_q != $past(synd_q))));

   // R6: success only with every check satisfied
   assert_success_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && succ_q) |-> (synd_q == '0));

   // R7: round count never passes the budget
   assert_round_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      round_q <= RND_W'(ROUND_LIMIT));

   // R10: exactly one outcome flag with each completion
   assert_outcome_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $onehot({succ_q, fail_q}));

   // R9: done lasts one cycle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: tb/bf_postproc_tb.sv
module bf_postproc_tb_top;

   localparam int NV  = 10;
   localparam int NC  = 6;
   localparam int LIM = 2;

   // own matrix: every pair of checks 0..4 covers one variable, check 5 covers none
   function automatic logic [NV*NC-1:0] build_h();
      logic [NV*NC-1:0] m;
      int v;
      m = '0;
      v = 0;
      for (int a = 0; a < 5; a++) begin
         for (int b = a + 1; b < 5; b++) begin
            m[v*NC + a] = 1'b1;
            m[v*NC + b] = 1'b1;
            v++;
         end
      end
      return m;
   endfunction

   localparam logic [NV*NC-1:0] TB_H = build_h();

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NV-1:0] hard_in = '0;
   logic [NC-1:0] synd_in = '0;
   logic busy, done, success, failure;
   logic [NV-1:0] word_out;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bf_postproc #(.N_VAR(NV), .N_CHK(NC), .ROUND_LIMIT(LIM), .H_COLS(TB_H)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .hard_in(hard_in), .synd_in(synd_in),
      .busy(busy), .done(done), .word_out(word_out), .success(success), .failure(failure)
   );

   function automatic logic [NC-1:0] col(input int v);
      return TB_H[v*NC +: NC];
   endfunction

   function automatic logic [NC-1:0] synd_of(input logic [NV-1:0] w);
      logic [NC-1:0] s = '0;
      for (int v = 0; v < NV; v++) if (w[v]) s ^= col(v);
      return s;
   endfunction

   // reference: flips < 0 means bypassed
   task automatic model(input logic [NV-1:0] hard, input logic [NC-1:0] syn,
                        output logic [NV-1:0] w, output bit succ, output int flips);
      logic [NC-1:0] s = syn;
      w = hard; succ = 0; flips = 0;
      if ($countones(syn) > 2*LIM) begin
         flips = -1;
         return;
      end
      forever begin
         int best, bidx;
         if (s == '0) begin succ = 1; return; end
         best = 0; bidx = 0;
         for (int v = 0; v < NV; v++) begin
            int c = $countones(s & col(v));
            if (c > best) begin best = c; bidx = v; end
         end
         if (best == 0 || flips == LIM) return;
         w[bidx] = ~w[bidx];
         s ^= col(bidx);
         flips++;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one run; poke holds start high with junk while busy (R10)
   task automatic run(input logic [NV-1:0] hard, input logic [NC-1:0] syn,
                      input string req, input bit poke);
      logic [NV-1:0] ew;
      bit es;
      int fl, edges, lat;
      model(hard, syn, ew, es, fl);
      lat = (fl < 0) ? 1 : fl + 2;
      @(negedge clk);
      start = 1'b1; hard_in = hard; synd_in = syn;
      @(posedge clk);
      edges = 1;
      @(negedge clk);
      start = poke;
      if (poke) begin hard_in = ~hard; synd_in = '1; end
      while (!done && edges < 100) begin
         @(posedge clk); edges++;
         @(negedge clk);
         if (done) start = 1'b0;
      end
      start = 1'b0;
      check(edges == lat, {req, " R9 latency"}, edges, lat);
      check(word_out == ew, {req, " word"}, int'(word_out), int'(ew));
      check(success == es, {req, " R6 success"}, int'(success), int'(es));
      check(failure == !es, {req, " R10 failure"}, int'(failure), int'(!es));
      @(negedge clk);
      check(!done, {req, " R9 pulse"}, int'(done), 0);
      check(success == es && failure == !es, {req, " R10 held"}, int'({success, failure}), int'({es, !es}));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int unused;
      unused = $urandom(32'h5eed_b17f);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !done && !success && !failure && word_out == '0, "R1 reset",
            int'({busy, done, success, failure}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: clean syndrome, nothing flipped
      run(10'h2a5, '0, "R6 zero", 0);
      // R3 R5: single error on variable 5 (checks 1,3)
      run(10'h020, 6'b001010, "R3 single", 0);
      // R4: checks 0..3 tie on six variables; lowest (v0) then v7
      run(10'h000, 6'b001111, "R4 tie", 0);
      // R2: five violated checks exceed 2*LIM
      run(10'h155, 6'b011111, "R2 bypass", 0);
      // R7: checks 0,1,2 need more than two flips
      run(10'h000, 6'b000111, "R7 limit", 0);
      // R8: check 5 is covered by no variable
      run(10'h3ff, 6'b100011, "R8 zero score", 0);
      // R10: start held high during a run is ignored
      run(10'h020, 6'b001010, "R10 ignore start", 1);
      for (int i = 0; i < 60; i++) begin
         logic [NV-1:0] e = '0;
         logic [NC-1:0] s;
         int k = $urandom_range(0, 3);
         for (int j = 0; j < k; j++) e[$urandom_range(0, NV-1)] = 1'b1;
         s = synd_of(e);
         if ($urandom_range(0, 3) == 0) s ^= NC'($urandom);
         run(e ^ NV'($urandom_range(0, 1) ? 0 : 0), s, "R3 random", 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule